// File: doc/BRIEF.md
# ECC SRAM Power-Up Zero-Fill Controller

This controller sits between a CPU-side request port and a single-port on-chip SRAM whose words are 39 bits wide: 32 data bits plus 7 check bits of a single-error-correcting, double-error-detecting code. When reset is released, the controller writes every word of the array, one word per clock in ascending address order. Each word gets zero data and the matching check bits, which for all-zero data are also all zero. Until that sweep has finished, memory requests from the CPU are held at the port by back-pressure and are not dropped. The held request goes to the array first once the sweep is done. A small status register can be read at any time, so software can poll for readiness.

Reads pass through the decoder. A single flipped bit is corrected in the returned data and sets a sticky flag. Two flipped bits set a separate sticky flag, and the data is returned as stored. A write with only some byte enables set takes a read-modify-write. The old word is read and checked, the enabled bytes are merged in, and the word is written back with fresh check bits. The sweep leaves valid check bits in every word, so this never reports an error on memory that was never written.

The request port is valid/ready. The requester raises `req_valid` and keeps the command fields stable until a rising edge at which `req_ready` is also high; that edge accepts the request. Every accepted request, read or write, produces exactly one response pulse on `rsp_valid`, in request order. The response side has no back-pressure, and the requester must take the response in the cycle it appears.

Top module: `eccram_ctrl`

## Requirements
- R1: After reset is released, the block writes the 39-bit all-zero word to addresses 0 up to DEPTH-1. It writes them in ascending order, one per clock, starting at the first clock edge after release. These sweep writes are the only writes in that window.
- R2: `sram_ready` is 0 in reset and during the sweep. It becomes 1 at the edge that writes the last address, which is DEPTH clock edges after reset release, and it then stays 1.
- R3: A request with `req_csr`=1 targets the status register. It is accepted in the first cycle it is offered, even during the sweep, and its response appears in the cycle after acceptance. Bit 0 of the status register is the ready flag, bit 1 is the sticky single-error flag and bit 2 is the sticky double-error flag; all other bits read 0.
- R4: A memory request offered during the sweep sees `req_ready`=0 until the sweep has finished. It is then performed, and a write made this way is visible to a later read.
- R5: A read, or a write with `req_be`=4'b1111, gets its response in the cycle after acceptance. A read returns the stored data, and a write response carries data 0.
- R6: A write with some but not all byte enables changes only the enabled bytes, where `req_be[i]` covers data bits 8i+7..8i. Its response appears two cycles after acceptance, with data 0.
- R7: When exactly one of the 39 stored bits of a word is wrong, a read, or the read half of a partial write, uses the corrected data and sets status bit 1.
- R8: When exactly two stored bits of a word are wrong, a read sets status bit 2 and leaves status bit 1 unchanged.
- R9: A status write clears bit 1 where write data bit 1 is 1, and clears bit 2 where write data bit 2 is 1. A 0 leaves the flag unchanged, and bit 0 cannot be changed by a write.
- R10: After the sweep, a partial write to a word that was never written, followed by a read of it, sets no error flag.
- R11: `rsp_valid` is never high in two consecutive cycles, and responses match accepted requests one to one, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_csr | input | 1 | 1 selects the status register, 0 selects the SRAM |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for SRAM writes |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data, or 0 for writes |
| sram_ready | output | 1 | Zero-fill sweep complete |
| mem_en | output | 1 | SRAM access this cycle |
| mem_we | output | 1 | SRAM write (1) or read (0) |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | 39 | SRAM write word, data and check bits |
| mem_rdata | input | 39 | SRAM read word, valid one cycle after a read |

## Verification
A sweep counter that skips or repeats an address shows up on the SRAM port within the first DEPTH cycles. It also moves the rise of `sram_ready` away from edge DEPTH, so a mistake there is visible before any CPU traffic runs. If the stall gating is wrong, a held write reaches the array during the sweep and is then overwritten by zero, or the sweep is cut short; the next read of that word returns the wrong data. Errors in the state machine or the merge path change either the response cycle or the bytes read back on the very next access. A wrong syndrome or a wrong flag update shows up on the next read of a corrupted word, or on the next status poll.

// File: rtl/eccram_pkg.sv
package eccram_pkg;
  localparam int DW = 32;
  localparam int PW = 6;
  localparam int HN = DW + PW;
  localparam int CW = HN + 1;

  localparam int STS_RDY = 0;
  localparam int STS_SGL = 1;
  localparam int STS_DBL = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RDATA, ST_MERGE, ST_RESP} st_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          sgl;
    logic          dbl;
  } dec_t;

  // Bit 0 holds overall parity; bits 1..HN are Hamming positions, with
  // parity at the powers of two and data at the remaining positions.
  function automatic logic [CW-1:0] secded_enc(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int i = 1; i <= HN; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PW; k++) begin
      logic p;
      p = 1'b0;
      for (int i = 1; i <= HN; i++) begin
        if (((i >> k) & 1) == 1) p = p ^ cw[i];
      end
      cw[1 << k] = p;
    end
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction

  function automatic dec_t secded_dec(input logic [CW-1:0] cw_in);
    logic [CW-1:0] cw;
    logic [PW-1:0] syn;
    logic          ovp;
    dec_t          r;
    int            j;
    cw  = cw_in;
    syn = '0;
    for (int i = 1; i <= HN; i++) begin
      if (cw[i]) syn = syn ^ PW'(i);
    end
    ovp   = ^cw;
    r.sgl = 1'b0;
    r.dbl = 1'b0;
    if (ovp) begin
      if (int'(syn) <= HN) begin
        r.sgl = 1'b1;
        if (syn != '0) cw[syn] = ~cw[syn];
      end else begin
        r.dbl = 1'b1;
      end
    end else if (syn != '0) begin
      r.dbl = 1'b1;
    end
    r.data = '0;
    j = 0;
    for (int i = 1; i <= HN; i++) begin
      if ((i & (i - 1)) != 0) begin
        r.data[j] = cw[i];
        j++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/eccram_sweep.sv
module eccram_sweep #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          active,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (addr_q == LAST) done_q <= 1'b1;
      else                addr_q <= addr_q + 1'b1;
    end
  end

  assign active = !done_q;
  assign addr   = addr_q;
  assign done   = done_q;

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && addr != LAST) |=> (addr == $past(addr) + 1'b1));

  // R2
  done_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && addr == LAST) |=> done);

  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/eccram_enc.sv
module eccram_enc
  import eccram_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] cw
);
  always_comb cw = secded_enc(data);
endmodule

// File: rtl/eccram_dec.sv
module eccram_dec
  import eccram_pkg::*;
(
  input  logic [CW-1:0] cw,
  output logic [DW-1:0] data,
  output logic          sgl,
  output logic          dbl
);
  dec_t r;
  always_comb begin
    r    = secded_dec(cw);
    data = r.data;
    sgl  = r.sgl;
    dbl  = r.dbl;
  end

  // R8
  always_comb begin
    sgl_dbl_excl_chk: assert (!(sgl && dbl));
  end
endmodule

// File: rtl/eccram_ctrl.sv
module eccram_ctrl
  import eccram_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_csr,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [3:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_wdata,
  input  logic [CW-1:0] mem_rdata
);
  localparam int NB = DW / 8;

  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] resp_q;
  logic          err_s_q, err_d_q;

  logic          sw_active, sw_done;
  logic [AW-1:0] sw_addr;
  logic [DW-1:0] dec_data, merged, enc_in, status_w;
  logic          dec_sgl, dec_dbl;
  logic [CW-1:0] enc_out;
  logic          accept, mem_acc, full_be;

  eccram_sweep #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .active(sw_active), .addr(sw_addr), .done(sw_done)
  );

  eccram_dec u_dec (.cw(mem_rdata), .data(dec_data), .sgl(dec_sgl), .dbl(dec_dbl));

  eccram_enc u_enc (.data(enc_in), .cw(enc_out));

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign enc_in    = (st_q == ST_MERGE) ? merged : req_wdata;
  assign full_be   = &req_be;
  assign req_ready = (st_q == ST_IDLE) && (req_csr || sw_done);
  assign accept    = req_valid && req_ready;
  assign mem_acc   = accept && !req_csr;

  always_comb begin
    status_w          = '0;
    status_w[STS_RDY] = sw_done;
    status_w[STS_SGL] = err_s_q;
    status_w[STS_DBL] = err_d_q;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (sw_active) begin
      mem_en   = 1'b1;
      mem_we   = 1'b1;
      mem_addr = sw_addr;
    end else if (mem_acc) begin
      mem_en    = 1'b1;
      mem_we    = req_write && full_be;
      mem_addr  = req_addr;
      mem_wdata = enc_out;
    end else if (st_q == ST_MERGE) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = addr_q;
      mem_wdata = enc_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      resp_q  <= '0;
      err_s_q <= 1'b0;
      err_d_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_csr) begin
              st_q   <= ST_RESP;
              resp_q <= req_write ? '0 : status_w;
              if (req_write && req_wdata[STS_SGL]) err_s_q <= 1'b0;
              if (req_write && req_wdata[STS_DBL]) err_d_q <= 1'b0;
            end else if (!req_write) begin
              st_q <= ST_RDATA;
            end else if (full_be) begin
              st_q   <= ST_RESP;
              resp_q <= '0;
            end else begin
              st_q    <= ST_MERGE;
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              be_q    <= req_be;
            end
          end
        end
        ST_RDATA: begin
          st_q <= ST_IDLE;
          if (dec_sgl) err_s_q <= 1'b1;
          if (dec_dbl) err_d_q <= 1'b1;
        end
        ST_MERGE: begin
          st_q   <= ST_RESP;
          resp_q <= '0;
          if (dec_sgl) err_s_q <= 1'b1;
          if (dec_dbl) err_d_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (st_q == ST_RDATA) || (st_q == ST_RESP);
  assign rsp_rdata  = (st_q == ST_RDATA) ? dec_data : resp_q;
  assign sram_ready = sw_done;

  // R4
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_csr && !sram_ready) |-> !req_ready);

  // R4
  sweep_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ready |-> (mem_wdata == '0));

  // R5
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_csr && !req_write) |=> rsp_valid);

  // R6
  merge_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_csr && req_write && !(&req_be))
      |=> (mem_we && mem_addr == $past(req_addr)));

  // R11
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/eccram_ctrl_bench.sv
module eccram_ctrl_bench;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = 39;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_csr = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_be = '0;
  logic          req_ready, rsp_valid, sram_ready, mem_en, mem_we;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_wdata, mem_rdata;

  eccram_ctrl #(.DEPTH(DEPTH)) u_eccram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_csr(req_csr), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sram_ready(sram_ready), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // SRAM model with a per-word bit-flip mask applied on reads
  logic [CW-1:0] sram [DEPTH];
  logic [CW-1:0] flip [DEPTH];
  logic [CW-1:0] rd_q;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else        rd_q <= sram[mem_addr] ^ flip[mem_addr];
    end
  end
  assign mem_rdata = rd_q;

  int checks = 0, errors = 0;
  int cyc = 0, rel_cyc = 0, ready_cyc = -1;
  int sweep_wr = 0, sweep_bad = 0;
  int last_acc_cyc = 0, last_rsp_cyc = 0;
  logic prev_rsp = 1'b0, finished = 1'b0;
  logic [32:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_en && mem_we && !sram_ready) begin
      if (mem_addr != sweep_wr[AW-1:0] || mem_wdata != '0) sweep_bad <= sweep_bad + 1;
      sweep_wr <= sweep_wr + 1;
    end
  end

  // Monitor: pop expected responses and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_ready && ready_cyc < 0) ready_cyc = cyc;
      if (ready_cyc >= 0 && !sram_ready) chk(1'b0, "R2 ready dropped", 0, 1);
      if (rsp_valid && prev_rsp) chk(1'b0, "R11 back-to-back rsp", 1, 0);
      if (rsp_valid) begin
        last_rsp_cyc = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected rsp", rsp_rdata, 0);
        else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e[32]) chk(rsp_rdata == e[31:0], t, rsp_rdata, e[31:0]);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_req(input logic csr, input logic wr, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        input logic care, input logic [31:0] exp, input string tag,
                        output int waited);
    logic rdy;
    @(posedge clk); #1;
    req_valid = 1'b1; req_csr = csr; req_write = wr;
    req_addr = a; req_wdata = d; req_be = be;
    exp_q.push_back({care, exp});
    tag_q.push_back(tag);
    waited = 0;
    forever begin
      @(negedge clk); rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      waited++;
    end
    #1;
    last_acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic op(input logic csr, input logic wr, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic [3:0] be,
                    input logic care, input logic [31:0] exp, input string tag);
    int w;
    do_req(csr, wr, a, d, be, care, exp, tag, w);
    settle();
  endtask

  initial begin
    int w;
    for (int i = 0; i < DEPTH; i++) flip[i] = '0;
    repeat (4) @(negedge clk);
    chk(sram_ready == 1'b0 && rsp_valid == 1'b0, "R2 reset state", {sram_ready, rsp_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    rel_cyc = cyc;

    // status poll during sweep: not stalled, ready bit 0
    do_req(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h0, "R3 status during sweep", w);
    chk(w == 0, "R3 status accepted at once", w, 0);
    settle();
    chk(last_rsp_cyc - last_acc_cyc == 0, "R3 status latency", last_rsp_cyc - last_acc_cyc, 0);
    chk(!sram_ready, "R2 still sweeping", sram_ready, 0);

    // memory write offered during sweep is held
    do_req(1'b0, 1'b1, 6'd5, 32'hA5A5_1234, 4'hF, 1'b1, 32'h0, "R5 write rsp", w);
    chk(w > 0, "R4 write stalled", w, 1);
    chk(sweep_wr == DEPTH, "R4 accepted after sweep", sweep_wr, DEPTH);
    settle();
    chk(last_rsp_cyc - last_acc_cyc == 0, "R5 write latency", last_rsp_cyc - last_acc_cyc, 0);
    chk(sweep_bad == 0 && sweep_wr == DEPTH, "R1 sweep order and zero data", sweep_bad, 0);
    chk(ready_cyc - rel_cyc == DEPTH, "R2 ready timing", ready_cyc - rel_cyc, DEPTH);

    do_req(1'b0, 1'b0, 6'd5, '0, 4'h0, 1'b1, 32'hA5A5_1234, "R4 held write visible", w);
    settle();
    chk(last_rsp_cyc - last_acc_cyc == 0, "R5 read latency", last_rsp_cyc - last_acc_cyc, 0);
    op(1'b0, 1'b0, 6'd9, '0, 4'h0, 1'b1, 32'h0, "R1 unwritten word reads zero");

    // partial writes
    do_req(1'b0, 1'b1, 6'd9, 32'h0000_AB00, 4'b0010, 1'b1, 32'h0, "R6 partial rsp", w);
    settle();
    chk(last_rsp_cyc - last_acc_cyc == 1, "R6 partial latency", last_rsp_cyc - last_acc_cyc, 1);
    op(1'b0, 1'b0, 6'd9, '0, 4'h0, 1'b1, 32'h0000_AB00, "R6 partial into fresh word");
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h1, "R10 no flag after partial on fresh word");
    op(1'b0, 1'b1, 6'd5, 32'h1122_3344, 4'b1001, 1'b1, 32'h0, "R6 partial rsp 2");
    op(1'b0, 1'b0, 6'd5, '0, 4'h0, 1'b1, 32'h11A5_1244, "R6 byte merge");
    op(1'b0, 1'b1, 6'd63, 32'hDEAD_BEEF, 4'hF, 1'b1, 32'h0, "R5 last word write");
    op(1'b0, 1'b0, 6'd63, '0, 4'h0, 1'b1, 32'hDEAD_BEEF, "R5 last word read");

    // single-bit error correction
    flip[5] = 39'h1 << 17;
    op(1'b0, 1'b0, 6'd5, '0, 4'h0, 1'b1, 32'h11A5_1244, "R7 corrected data");
    flip[5] = '0;
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h3, "R7 single flag set");
    op(1'b1, 1'b1, '0, 32'h0, 4'hF, 1'b1, 32'h0, "R9 write zero");
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h3, "R9 zero keeps flag");
    op(1'b1, 1'b1, '0, 32'h3, 4'hF, 1'b1, 32'h0, "R9 clear single");
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h1, "R9 single cleared, ready kept");

    flip[63] = 39'h1;
    op(1'b0, 1'b0, 6'd63, '0, 4'h0, 1'b1, 32'hDEAD_BEEF, "R7 parity bit error corrected");
    flip[63] = '0;
    op(1'b1, 1'b1, '0, 32'h2, 4'hF, 1'b1, 32'h0, "R9 clear single 2");

    // single error under a partial write
    flip[63] = 39'h1 << 30;
    op(1'b0, 1'b1, 6'd63, 32'h0000_0077, 4'b0001, 1'b1, 32'h0, "R7 partial rsp");
    flip[63] = '0;
    op(1'b0, 1'b0, 6'd63, '0, 4'h0, 1'b1, 32'hDEAD_BE77, "R7 merge uses corrected word");
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h3, "R7 flag from merge read");
    op(1'b1, 1'b1, '0, 32'h2, 4'hF, 1'b1, 32'h0, "R9 clear single 3");

    // double-bit error
    flip[9] = (39'h1 << 3) | (39'h1 << 30);
    op(1'b0, 1'b0, 6'd9, '0, 4'h0, 1'b0, 32'h0, "R8 double read");
    flip[9] = '0;
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h5, "R8 double flag only");
    op(1'b1, 1'b1, '0, 32'h4, 4'hF, 1'b1, 32'h0, "R9 clear double");
    op(1'b1, 1'b0, '0, '0, 4'h0, 1'b1, 32'h1, "R9 double cleared");

    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule